// File: doc/BRIEF.md
# Configurable FIR/IIR Filter Engine

A fixed-point filter datapath that runs either a finite impulse response filter or a direct-form-1 infinite impulse response filter over 16-bit Q1.15 samples held in a memory outside the block. When the start input goes high, the engine latches a function code, two tap counts, an output gain and the bases and sizes of three memory regions: coefficients, input samples and output samples. It then produces one output sample each time the input region holds enough samples. It keeps doing this until the start input is dropped.

For each output the engine walks every tap over two read ports with one cycle of read latency. One port fetches coefficients and the other fetches samples. Each product goes into a 40-bit accumulator. The engine then applies the gain shift and saturates the result to 16 bits. It writes the result into the circular output region, advances the circular input read pointer by one and pulses `x_pop_o`. The stored outputs are read back as the feedback terms of the IIR function. Buffer fill tracking is kept outside the block and reaches it as the `x_level_i` count.

Top module: `fe_engine`

## Requirements
- R1: While idle with `start_i` high, the engine latches its configuration. `func_i` = 8 selects FIR with N = `p_i` and M = 0, and `q_i` is ignored. `func_i` = 9 selects IIR with N = `p_i` feed-forward taps and M = `q_i` feedback taps.
- R2: Processing continues sample after sample while `start_i` stays high. When `start_i` is low, the engine returns to idle at the next sample boundary without writing another output, and `busy_o` falls.
- R3: An output is computed only when `x_level_i` >= N, where `x_level_i` counts the samples present from the read pointer onward, pre-loaded ones included.
- R4: Each output is written with a single-cycle `w_en_o` pulse at `y_base_i + wp`. The same cycle carries an `x_pop_o` pulse. Both pointers start at 0 at each start and advance by one modulo `x_size_i` (read pointer rp) and modulo `y_size_i` (write pointer wp).
- R5: The FIR sum is acc = sum over i < N of c[i]·x[(rp+i) mod x_size], where c[i] is read from `c_base_i + i`. c[0] therefore weights the oldest sample in the window. Products are Q2.30 values and are summed exactly in 40 bits, so 127 full-scale products cannot overflow.
- R6: In IIR mode the sum also includes, for j < M, c[N+j]·y[(wp−M+j) mod y_size]. Here c[N+j] is read from `c_base_i + N + j` and y is read from the output region, so the oldest stored output pairs with c[N].
- R7: The output is (acc << R) >> 15 (arithmetic, truncating), with R = `r_i` in the range 0..7, clipped to [−32768, 32767]. `sat_o` is set by any clipped output, stays set until the next start, and is cleared at that start.
- R8: Any of the following conditions raises `cfg_err_o`, which holds until `start_i` falls, and no memory access happens while it is raised: a function code other than 8 or 9, N = 0, IIR with M = 0 or M >= N, N+M > 127, `x_size_i` < N, `y_size_i` < M, or `y_size_i` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run while high |
| func_i | input | 8 | Function code (8 FIR, 9 IIR) |
| p_i | input | 8 | Feed-forward tap count N |
| q_i | input | 8 | Feedback tap count M (IIR only) |
| r_i | input | 3 | Output gain shift |
| c_base_i | input | 8 | Coefficient region base |
| x_base_i | input | 8 | Input region base |
| x_size_i | input | 8 | Input region size |
| y_base_i | input | 8 | Output region base |
| y_size_i | input | 8 | Output region size |
| x_level_i | input | 8 | Samples available from the read pointer |
| c_addr_o | output | 8 | Coefficient read address |
| c_rdata_i | input | 16 | Coefficient read data, one cycle after address |
| d_addr_o | output | 8 | Sample read address |
| d_rdata_i | input | 16 | Sample read data, one cycle after address |
| w_en_o | output | 1 | Output write strobe |
| w_addr_o | output | 8 | Output write address |
| w_data_o | output | 16 | Output sample |
| x_pop_o | output | 1 | One input sample consumed |
| busy_o | output | 1 | Engine running |
| cfg_err_o | output | 1 | Rejected configuration |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
The bench builds the engine with its default parameters: 16-bit data, 8-bit addresses, a 40-bit accumulator and a limit of 127 taps. This lets a 256-word model memory hold the largest IIR case, N = 64 with M = 63, which puts 127 full products into one sum. Small input and output region sizes force both circular pointers to wrap several times within one run. Full-scale operands combined with a gain of 7 drive both saturation limits.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam logic [7:0] FN_FIR = 8'd8;
  localparam logic [7:0] FN_IIR = 8'd9;

  typedef enum logic [2:0] {
    S_IDLE, S_ERR, S_WAIT, S_RUN, S_DRAIN, S_WRITE
  } fe_state_e;
endpackage

// File: rtl/fe_mac.sv
module fe_mac #(
  parameter int DW    = 16,
  parameter int ACC_W = 40
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    v_i,
  input  logic [DW-1:0]           a_i,
  input  logic [DW-1:0]           b_i,
  output logic signed [ACC_W-1:0] acc_o
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0]    prod;
  logic signed [ACC_W-1:0] prod_x;

  assign prod   = $signed(a_i) * $signed(b_i);
  assign prod_x = $signed({{(ACC_W-PW){prod[PW-1]}}, prod});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_o <= '0;
    else if (clr_i) acc_o <= '0;
    else if (v_i)   acc_o <= acc_o + prod_x;
  end
endmodule

// File: rtl/fe_out.sv
module fe_out #(
  parameter int DW    = 16,
  parameter int ACC_W = 40,
  parameter int RW    = 3
) (
  input  logic signed [ACC_W-1:0] acc_i,
  input  logic [RW-1:0]           r_i,
  output logic [DW-1:0]           y_o,
  output logic                    clip_o
);
  localparam int SW = ACC_W + (1 << RW);
  localparam logic signed [SW-1:0] MAXV = SW'((64'sd1 <<< (DW-1)) - 1);
  localparam logic signed [SW-1:0] MINV = -MAXV - 1;

  logic signed [SW-1:0] ext, sh, val;
  logic hi, lo;

  always_comb begin
    ext = $signed({{(SW-ACC_W){acc_i[ACC_W-1]}}, acc_i});
    sh  = ext <<< r_i;
    val = sh >>> (DW-1);
    hi  = val > MAXV;
    lo  = val < MINV;
    if (hi)      y_o = {1'b0, {(DW-1){1'b1}}};
    else if (lo) y_o = {1'b1, {(DW-1){1'b0}}};
    else         y_o = val[DW-1:0];
    clip_o = hi | lo;
  end
endmodule

// File: rtl/fe_ctrl.sv
module fe_ctrl
  import fe_pkg::*;
#(
  parameter int AW       = 8,
  parameter int RW       = 3,
  parameter int MAX_TAPS = 127
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [7:0]    func_i,
  input  logic [AW-1:0] p_i,
  input  logic [AW-1:0] q_i,
  input  logic [RW-1:0] r_i,
  input  logic [AW-1:0] c_base_i,
  input  logic [AW-1:0] x_base_i,
  input  logic [AW-1:0] x_size_i,
  input  logic [AW-1:0] y_base_i,
  input  logic [AW-1:0] y_size_i,
  input  logic [AW-1:0] x_level_i,
  input  logic          clip_i,
  output logic [AW-1:0] c_addr_o,
  output logic [AW-1:0] d_addr_o,
  output logic [AW-1:0] w_addr_o,
  output logic          rd_v_o,
  output logic          acc_clr_o,
  output logic          w_en_o,
  output logic          x_pop_o,
  output logic          busy_o,
  output logic          cfg_err_o,
  output logic          sat_o,
  output logic [RW-1:0] r_o,
  output logic [AW:0]   t_o
);
  localparam logic [AW:0] TAPS_LIM = (AW+1)'(MAX_TAPS);

  fe_state_e st_q;
  logic [AW-1:0] n_q, m_q, cb_q, xb_q, xs_q, yb_q, ys_q;
  logic [AW-1:0] rp_q, wp_q, xo_q, yo_q, y_first, m_in;
  logic [AW:0]   k_q, t_in;
  logic          is_fir, is_iir, cfg_ok, x_tap, last, sat_q;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] v, input logic [AW-1:0] sz);
    return (v == sz - 1'b1) ? '0 : v + 1'b1;
  endfunction

  assign is_fir = func_i == FN_FIR;
  assign is_iir = func_i == FN_IIR;
  assign m_in   = is_iir ? q_i : '0;
  assign t_in   = {1'b0, p_i} + {1'b0, m_in};
  assign cfg_ok = (is_fir || is_iir) && p_i != '0 &&
                  (!is_iir || (q_i != '0 && q_i < p_i)) &&
                  t_in <= TAPS_LIM && x_size_i >= p_i &&
                  y_size_i >= m_in && y_size_i != '0;

  assign t_o     = {1'b0, n_q} + {1'b0, m_q};
  assign x_tap   = k_q < {1'b0, n_q};
  assign last    = k_q == t_o - 1'b1;
  assign y_first = (wp_q >= m_q) ? wp_q - m_q : wp_q + ys_q - m_q;

  assign c_addr_o  = cb_q + k_q[AW-1:0];
  assign d_addr_o  = x_tap ? xb_q + xo_q : yb_q + yo_q;
  assign w_addr_o  = yb_q + wp_q;
  assign rd_v_o    = st_q == S_RUN;
  assign acc_clr_o = st_q == S_WAIT && start_i && x_level_i >= n_q;
  assign w_en_o    = st_q == S_WRITE;
  assign x_pop_o   = st_q == S_WRITE;
  assign busy_o    = st_q != S_IDLE && st_q != S_ERR;
  assign cfg_err_o = st_q == S_ERR;
  assign sat_o     = sat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;
      n_q <= '0; m_q <= '0; r_o <= '0; cb_q <= '0;
      xb_q <= '0; xs_q <= '0; yb_q <= '0; ys_q <= '0;
      rp_q <= '0; wp_q <= '0; xo_q <= '0; yo_q <= '0;
      k_q <= '0; sat_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          n_q <= p_i; m_q <= m_in; r_o <= r_i; cb_q <= c_base_i;
          xb_q <= x_base_i; xs_q <= x_size_i; yb_q <= y_base_i; ys_q <= y_size_i;
          rp_q <= '0; wp_q <= '0; sat_q <= 1'b0;
          st_q <= cfg_ok ? S_WAIT : S_ERR;
        end
        S_ERR: if (!start_i) st_q <= S_IDLE;
        S_WAIT:
          if (!start_i) st_q <= S_IDLE;
          else if (x_level_i >= n_q) begin
            k_q <= '0; xo_q <= rp_q; yo_q <= y_first; st_q <= S_RUN;
          end
        S_RUN: begin
          k_q <= k_q + 1'b1;
          if (x_tap) xo_q <= wrap_inc(xo_q, xs_q);
          else       yo_q <= wrap_inc(yo_q, ys_q);
          if (last)  st_q <= S_DRAIN;
        end
        S_DRAIN: st_q <= S_WRITE;
        S_WRITE: begin
          sat_q <= sat_q | clip_i;
          rp_q  <= wrap_inc(rp_q, xs_q);
          wp_q  <= wrap_inc(wp_q, ys_q);
          st_q  <= S_WAIT;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_one_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_en_o |=> !w_en_o);
  p_x_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_v_o && x_tap) |-> (AW'(d_addr_o - xb_q) < xs_q));
  p_y_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_v_o && !x_tap) |-> (AW'(d_addr_o - yb_q) < ys_q));
  p_err_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!busy_o && !w_en_o && !rd_v_o));
  p_stop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !rd_v_o && !w_en_o && !start_i && st_q == S_WAIT) |=> !busy_o);
endmodule

// File: rtl/fe_engine.sv
module fe_engine #(
  parameter int DW       = 16,
  parameter int AW       = 8,
  parameter int ACC_W    = 40,
  parameter int RW       = 3,
  parameter int MAX_TAPS = 127
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [7:0]    func_i,
  input  logic [AW-1:0] p_i,
  input  logic [AW-1:0] q_i,
  input  logic [RW-1:0] r_i,
  input  logic [AW-1:0] c_base_i,
  input  logic [AW-1:0] x_base_i,
  input  logic [AW-1:0] x_size_i,
  input  logic [AW-1:0] y_base_i,
  input  logic [AW-1:0] y_size_i,
  input  logic [AW-1:0] x_level_i,
  output logic [AW-1:0] c_addr_o,
  input  logic [DW-1:0] c_rdata_i,
  output logic [AW-1:0] d_addr_o,
  input  logic [DW-1:0] d_rdata_i,
  output logic          w_en_o,
  output logic [AW-1:0] w_addr_o,
  output logic [DW-1:0] w_data_o,
  output logic          x_pop_o,
  output logic          busy_o,
  output logic          cfg_err_o,
  output logic          sat_o
);
  logic                    rd_v, rd_v_q, acc_clr, clip;
  logic [RW-1:0]           r_lat;
  logic [AW:0]             taps, tap_cnt_q;
  logic signed [ACC_W-1:0] acc;

  fe_ctrl #(.AW(AW), .RW(RW), .MAX_TAPS(MAX_TAPS)) i_ctrl (
    .clk_i, .rst_ni, .start_i, .func_i, .p_i, .q_i, .r_i,
    .c_base_i, .x_base_i, .x_size_i, .y_base_i, .y_size_i, .x_level_i,
    .clip_i(clip), .c_addr_o, .d_addr_o, .w_addr_o,
    .rd_v_o(rd_v), .acc_clr_o(acc_clr), .w_en_o, .x_pop_o,
    .busy_o, .cfg_err_o, .sat_o, .r_o(r_lat), .t_o(taps)
  );

  // memory returns data one cycle after the address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_v_q <= 1'b0;
    else         rd_v_q <= rd_v;
  end

  fe_mac #(.DW(DW), .ACC_W(ACC_W)) i_mac (
    .clk_i, .rst_ni, .clr_i(acc_clr), .v_i(rd_v_q),
    .a_i(c_rdata_i), .b_i(d_rdata_i), .acc_o(acc)
  );

  fe_out #(.DW(DW), .ACC_W(ACC_W), .RW(RW)) i_out (
    .acc_i(acc), .r_i(r_lat), .y_o(w_data_o), .clip_o(clip)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tap_cnt_q <= '0;
    else if (acc_clr) tap_cnt_q <= '0;
    else if (rd_v_q)  tap_cnt_q <= tap_cnt_q + 1'b1;
  end

  p_taps_per_output_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_en_o |-> tap_cnt_q == taps);
  p_sat_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_o && busy_o) |=> sat_o);
  p_pop_with_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_pop_o |-> (w_en_o && !rd_v_q));
endmodule

// File: tb/test_fe_engine.sv
`timescale 1ns/1ps
module test_fe_engine;
  localparam int CB = 0, XB = 127, YB = 192;

  typedef struct packed {
    logic [7:0] func, n, q, r, xs, ys, tot, amp;
    logic [15:0] seed;
  } vec_t;

  localparam vec_t VEC [0:4] = '{
    '{8'd8, 8'd4,  8'd5,  8'd0, 8'd6,  8'd4,  8'd12, 8'd2, 16'd1},
    '{8'd8, 8'd16, 8'd0,  8'd2, 8'd20, 8'd5,  8'd30, 8'd3, 16'd7},
    '{8'd9, 8'd3,  8'd2,  8'd1, 8'd5,  8'd3,  8'd14, 8'd3, 16'd11},
    '{8'd9, 8'd8,  8'd7,  8'd7, 8'd9,  8'd7,  8'd20, 8'd0, 16'd23},
    '{8'd9, 8'd64, 8'd63, 8'd0, 8'd65, 8'd64, 8'd80, 8'd5, 16'd5}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic start = 0;
  logic [7:0] func = 0, p = 0, q = 0, xs = 1, ys = 1;
  logic [2:0] r = 0;
  logic [7:0] c_addr, d_addr, w_addr, x_level;
  logic [15:0] c_rd, d_rd, w_data;
  logic w_en, x_pop, busy, cfg_err, sat;

  logic [15:0] mem [0:255];
  logic signed [15:0] cf [0:127];
  logic signed [15:0] xin [0:255];
  logic signed [15:0] ye [0:255];
  logic [15:0] got_d [0:255];
  logic [7:0]  got_a [0:255];
  logic ld_en = 0, cnt_clr = 0;
  logic [7:0] ld_a = 0;
  logic [15:0] ld_d = 0;
  int pops = 0, fed = 0, wcnt = 0, pre = 0, tot_q = 0, xs_q = 1, lim = 255;
  int checks = 0, errors = 0, avail;

  fe_engine i_fe_engine (
    .clk_i, .rst_ni, .start_i(start), .func_i(func), .p_i(p), .q_i(q), .r_i(r),
    .c_base_i(8'(CB)), .x_base_i(8'(XB)), .x_size_i(xs), .y_base_i(8'(YB)), .y_size_i(ys),
    .x_level_i(x_level), .c_addr_o(c_addr), .c_rdata_i(c_rd), .d_addr_o(d_addr),
    .d_rdata_i(d_rd), .w_en_o(w_en), .w_addr_o(w_addr), .w_data_o(w_data),
    .x_pop_o(x_pop), .busy_o(busy), .cfg_err_o(cfg_err), .sat_o(sat)
  );

  assign avail   = pre + fed - pops;
  assign x_level = 8'((avail > lim) ? lim : avail);

  always @(posedge clk_i) begin
    c_rd <= mem[c_addr];
    d_rd <= mem[d_addr];
    if (ld_en) mem[ld_a] <= ld_d;
    if (cnt_clr) begin
      pops <= 0; fed <= 0; wcnt <= 0;
    end else begin
      if (w_en) begin
        mem[w_addr] <= w_data;
        got_d[wcnt] <= w_data;
        got_a[wcnt] <= w_addr;
        wcnt <= wcnt + 1;
      end
      if (x_pop) begin
        pops <= pops + 1;
        if (pre + fed < tot_q) begin
          mem[8'(XB + (pre + fed) % xs_q)] <= xin[pre + fed];
          fed <= fed + 1;
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr_mem(input int a, input logic [15:0] d);
    ld_a = 8'(a); ld_d = d; ld_en = 1'b1;
    tick(1);
    ld_en = 1'b0;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_case(input int fn, input int n, input int qq, input int rr,
                          input int xsz, input int ysz, input int tot,
                          input bit hold, input int stop_at);
    int m, nout, target, cyc;
    bit sat_e;
    longint acc, v;
    m = (fn == 9) ? qq : 0;
    for (int i = 0; i < n + m; i++) wr_mem(CB + i, cf[i]);
    for (int i = 0; i < xsz; i++) wr_mem(XB + i, (i < tot) ? xin[i] : 16'h0);
    for (int i = 0; i < ysz; i++) wr_mem(YB + i, 16'h0);
    nout = tot - n + 1;
    sat_e = 0;
    for (int s = 0; s < nout; s++) begin
      acc = 0;
      for (int i = 0; i < n; i++) acc += longint'(cf[i]) * longint'(xin[s + i]);
      for (int j = 0; j < m; j++)
        if (s - m + j >= 0) acc += longint'(cf[n + j]) * longint'(ye[s - m + j]);
      v = (acc <<< rr) >>> 15;
      if (v > 32767) begin ye[s] = 16'sh7fff; sat_e = 1; end
      else if (v < -32768) begin ye[s] = -16'sh8000; sat_e = 1; end
      else ye[s] = 16'(v);
    end
    pre = (xsz < tot) ? xsz : tot;
    tot_q = tot; xs_q = xsz;
    lim = hold ? n - 1 : 255;
    cnt_clr = 1; tick(1); cnt_clr = 0;
    func = 8'(fn); p = 8'(n); q = 8'(qq); r = 3'(rr); xs = 8'(xsz); ys = 8'(ysz);
    start = 1;
    if (hold) begin
      tick(40);
      check(wcnt == 0, "R3", "output before N samples", wcnt, 0);
      check(busy == 1, "R3", "busy while waiting", busy, 1);
      lim = 255;
    end
    target = (stop_at > 0) ? stop_at : nout;
    cyc = 0;
    while (wcnt < target && cyc < 30000) begin tick(1); cyc++; end
    start = 0;
    tick(n + m + 8);
    check(busy == 0, "R2", "busy after stop", busy, 0);
    check(wcnt == target, "R2", "output count", wcnt, target);
    check(pops == target, "R4", "pop count", pops, target);
    for (int s = 0; s < wcnt && s < nout; s++) begin
      check(got_d[s] == 16'(ye[s]), (m > 0) ? "R6" : "R5", $sformatf("y[%0d]", s),
            got_d[s], 16'(ye[s]));
      check(got_a[s] == 8'(YB + s % ysz), "R4", $sformatf("addr[%0d]", s),
            got_a[s], 8'(YB + s % ysz));
    end
    if (stop_at == 0)
      check(sat == sat_e, "R7", "sticky saturation flag", sat, sat_e);
  endtask

  task automatic cfg_bad(input int fn, input int n, input int qq, input int xsz, input int ysz);
    cnt_clr = 1; tick(1); cnt_clr = 0;
    pre = 0; tot_q = 0; lim = 255;
    func = 8'(fn); p = 8'(n); q = 8'(qq); xs = 8'(xsz); ys = 8'(ysz);
    start = 1;
    tick(4);
    check(cfg_err == 1, "R8", $sformatf("error raised f%0d n%0d q%0d", fn, n, qq), cfg_err, 1);
    check(busy == 0 && wcnt == 0, "R8", "no activity on error", busy, 0);
    start = 0;
    tick(2);
    check(cfg_err == 0, "R8", "error clears with start low", cfg_err, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] st;
    tick(3);
    check(busy == 0, "R2", "reset busy", busy, 0);
    check(w_en == 0 && x_pop == 0, "R4", "reset strobes", w_en, 0);
    check(cfg_err == 0, "R8", "reset error", cfg_err, 0);
    check(sat == 0, "R7", "reset saturation", sat, 0);
    rst_ni = 1;
    tick(2);

    // R1 decode: table cases cover FIR with q ignored, IIR wrap, 127 taps
    foreach (VEC[v]) begin
      int m;
      st = 32'(VEC[v].seed);
      m = (VEC[v].func == 8'd9) ? int'(VEC[v].q) : 0;
      for (int i = 0; i < VEC[v].n + m; i++) begin
        st = st * 32'd1103515245 + 32'd12345;
        cf[i] = $signed(st[30:15]) >>> VEC[v].amp;
      end
      for (int i = 0; i < VEC[v].tot; i++) begin
        st = st * 32'd1103515245 + 32'd12345;
        xin[i] = $signed(st[30:15]) >>> VEC[v].amp;
      end
      run_case(VEC[v].func, VEC[v].n, VEC[v].q, VEC[v].r, VEC[v].xs, VEC[v].ys,
               VEC[v].tot, 1'b0, 0);
    end

    // R7 both clip limits with full-scale operands
    cf[0] = 16'sh7fff;
    xin[0] = 16'sh7fff; xin[1] = -16'sh8000; xin[2] = 16'sh0100;
    xin[3] = -16'sh0100; xin[4] = 16'sh0000;
    run_case(8, 1, 0, 7, 5, 2, 5, 1'b0, 0);

    // R3 first output waits for N samples; R7 flag cleared by new start
    for (int i = 0; i < 4; i++) cf[i] = 16'(i * 300 + 100);
    for (int i = 0; i < 6; i++) xin[i] = 16'(i * 500 - 1000);
    run_case(8, 4, 0, 0, 6, 3, 6, 1'b1, 0);

    // R2 stop mid-stream at a sample boundary
    for (int i = 0; i < 40; i++) xin[i] = 16'(i * 97 - 1500);
    run_case(8, 4, 0, 1, 6, 4, 40, 1'b0, 5);

    // R8 rejected configurations
    cfg_bad(3, 4, 0, 6, 4);
    cfg_bad(9, 4, 0, 6, 4);
    cfg_bad(9, 4, 4, 6, 4);
    cfg_bad(8, 8, 0, 6, 4);
    cfg_bad(8, 0, 0, 6, 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule